// File: doc/BRIEF.md
# Dual-Source Ready Synchronizer

This block merges two ready requests, each gated by its own enable, into one ready line for a processor bus. It brings that line into the processor clock domain through one or two flip-flop stages. The combined request is high when either source is both ready and enabled.

A mode pin sets the depth of the synchronizer. With one stage, the combined request is captured directly by a falling-edge flop. With two stages, a rising-edge flop captures it first, and the falling-edge flop takes its value half a cycle later. In both modes the output moves only on falling clock edges.

All pins are plain control levels. The block has no data stream and therefore no valid/ready handshake or back-pressure. Reset is asynchronous and active low, and it clears both flops.

Top module: `rdy_sync_top`

## Requirements
- R1: The combined request is (rdy_a AND en_a) OR (rdy_b AND en_b).
- R2: When one_stage is 1 at a falling clock edge, rdy_out takes the combined request present at that falling edge.
- R3: When one_stage is 0 at a falling clock edge, rdy_out takes the combined request that was present at the preceding rising edge.
- R4: rdy_out changes only on falling clock edges, apart from reset. A rising edge never moves it.
- R5: While rst_n is 0, rdy_out is 0. It drops without waiting for a clock edge.
- R6: A change of one_stage takes effect at the next falling edge. That edge uses the mode present when it occurs, and the output changes cleanly at that edge.
- R7: A ready input whose enable is 0 does not contribute to the combined request. Enable 1 means the paired ready is honoured.
- R8: Reset also clears the rising-edge stage. In two-stage mode, after reset is released between a rising and a falling edge, the first falling edge gives 0 even if the combined request is already 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; stage one on rising, final stage on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_a | input | 1 | Ready request from source A |
| en_a | input | 1 | Enable qualifying rdy_a |
| rdy_b | input | 1 | Ready request from source B |
| en_b | input | 1 | Enable qualifying rdy_b |
| one_stage | input | 1 | 1 selects one synchronizing stage, 0 selects two |
| rdy_out | output | 1 | Synchronized ready toward the processor |

## Verification
A mode switch and a change of the combined request can land in the same clock phase. The falling edge then has to choose between the fresh request and the value held in the rising-edge stage. The bench provokes this by setting one request pattern before a rising edge, then switching the mode together with a different pattern after that edge. The output after the falling edge is judged against the mode that holds at that edge: the fresh pattern for one stage, the earlier pattern for two stages.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;
  // number of ready/enable source pairs merged by the block
  localparam int SRC_CNT = 2;

  typedef enum logic {
    SYNC_TWO = 1'b0,
    SYNC_ONE = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic         merged
);
  logic [N-1:0] term;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign term[i] = req[i] & en[i];
  end

  assign merged = |term;
endmodule

// File: rtl/rdy_rise_stage.sv
module rdy_rise_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/rdy_fall_stage.sv
module rdy_fall_stage
  import rdy_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic direct,
  input  logic staged,
  output logic q
);
  sync_mode_e mode;
  assign mode = sync_mode_e'(mode_sel);

  // mode is sampled by this flop only, so a switch cannot glitch q
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                q <= 1'b0;
    else if (mode == SYNC_ONE) q <= direct;
    else                       q <= staged;
  end
endmodule

// File: rtl/rdy_sync_top.sv
module rdy_sync_top
  import rdy_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_a,
  input  logic en_a,
  input  logic rdy_b,
  input  logic en_b,
  input  logic one_stage,
  output logic rdy_out
);
  logic raw_req;
  logic first_q;

  rdy_qualify #(.N(SRC_CNT)) u_qual (
    .req    ({rdy_b, rdy_a}),
    .en     ({en_b, en_a}),
    .merged (raw_req)
  );

  rdy_rise_stage u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_req),
    .q     (first_q)
  );

  rdy_fall_stage u_fall (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (one_stage),
    .direct   (raw_req),
    .staged   (first_q),
    .q        (rdy_out)
  );
endmodule

// File: rtl/rdy_sync_chk.sv
module rdy_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_a,
  input logic en_a,
  input logic rdy_b,
  input logic en_b,
  input logic one_stage,
  input logic rdy_out
);
  logic req_now;
  logic req_at_rise;
  logic out_at_rise;

  assign req_now = (rdy_a & en_a) | (rdy_b & en_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_at_rise <= 1'b0;
      out_at_rise <= 1'b0;
    end else begin
      req_at_rise <= req_now;
      out_at_rise <= rdy_out;
    end
  end

  // R2 R6 R1
  single_stage_chk: assert property (@(negedge clk) disable iff (!rst_n)
    one_stage |=> (rdy_out == $past(req_now)));

  // R3 R6
  two_stage_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !one_stage |=> (rdy_out == $past(req_at_rise)));

  // R4
  fall_only_chk: assert property (@(negedge clk) disable iff (!rst_n)
    rdy_out == out_at_rise);

  // R5
  reset_low_chk: assert property (@(negedge clk)
    !rst_n |=> !rdy_out);
endmodule

bind rdy_sync_top rdy_sync_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy_a     (rdy_a),
  .en_a      (en_a),
  .rdy_b     (rdy_b),
  .en_b      (en_b),
  .one_stage (one_stage),
  .rdy_out   (rdy_out)
);

// File: tb/tb_rdy_sync_top.sv
module tb_rdy_sync_top;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy_a = 1'b0, en_a = 1'b0, rdy_b = 1'b0, en_b = 1'b0;
  logic one_stage = 1'b1;
  logic rdy_out;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  rdy_sync_top dut (
    .clk(clk), .rst_n(rst_n), .rdy_a(rdy_a), .en_a(en_a),
    .rdy_b(rdy_b), .en_b(en_b), .one_stage(one_stage), .rdy_out(rdy_out)
  );

  // {mode, patA{ra,ea,rb,eb}, patB{ra,ea,rb,eb}, expected}
  // patA is applied before the rising edge, patB after it.
  localparam logic [9:0] VEC [0:11] = '{
    {1'b1, 4'b1100, 4'b0000, 1'b0},
    {1'b0, 4'b1100, 4'b0000, 1'b1},
    {1'b1, 4'b0000, 4'b0011, 1'b1},
    {1'b0, 4'b0000, 4'b0011, 1'b0},
    {1'b0, 4'b1000, 4'b1111, 1'b0},
    {1'b1, 4'b1111, 4'b1011, 1'b1},
    {1'b1, 4'b0000, 4'b1110, 1'b1},
    {1'b1, 4'b0000, 4'b0111, 1'b1},
    {1'b1, 4'b1111, 4'b1001, 1'b0},
    {1'b0, 4'b0110, 4'b1111, 1'b0},
    {1'b0, 4'b0111, 4'b0000, 1'b1},
    {1'b1, 4'b0000, 4'b1010, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] p);
    {rdy_a, en_a, rdy_b, en_b} = p;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 5000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // reset state: R5
    put(4'b1111);
    #(CLK_T * 2 + 2);
    check(rdy_out, 1'b0, "R5 reset state");
    @(negedge clk); #1 rst_n = 1'b1;

    // vector table: R1 R2 R3 R7
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1 one_stage = VEC[i][9]; put(VEC[i][8:5]);
      #6 put(VEC[i][4:1]);
      #5 check(rdy_out, VEC[i][0], VEC[i][9] ? "R1 R2 R7" : "R1 R3 R7");
    end

    // R4: rising edge leaves the output alone (single stage, 0 -> 1)
    @(negedge clk); #1 one_stage = 1'b1; put(4'b0000);
    @(negedge clk); #1 put(4'b1100);
    #3 check(rdy_out, 1'b0, "R4 before rise");
    #3 check(rdy_out, 1'b0, "R4 after rise");
    #5 check(rdy_out, 1'b1, "R4 at fall");

    // R6: two-stage -> single-stage switch after the rising edge
    @(negedge clk); #1 one_stage = 1'b0; put(4'b0000);
    #6 one_stage = 1'b1; put(4'b0011);
    #5 check(rdy_out, 1'b1, "R6 to single");
    // R6: single-stage -> two-stage switch after the rising edge
    @(negedge clk); #1 one_stage = 1'b1; put(4'b0000);
    #6 one_stage = 1'b0; put(4'b0011);
    #5 check(rdy_out, 1'b0, "R6 to double");

    // R5: asynchronous clear mid-cycle with output high
    @(negedge clk); #1 one_stage = 1'b1; put(4'b1100);
    @(negedge clk); #1 check(rdy_out, 1'b1, "R5 high before reset");
    #2 rst_n = 1'b0;
    #1 check(rdy_out, 1'b0, "R5 async clear");

    // R8: release after a rising edge in two-stage mode
    one_stage = 1'b0; put(4'b1100);
    @(negedge clk); #1;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #2 check(rdy_out, 1'b0, "R8 first stage cleared");
    @(negedge clk); #2 check(rdy_out, 1'b1, "R8 request passes next");

    #(CLK_T);
    finish_run();
  end
endmodule